// File: doc/BRIEF.md
# Multichannel DMA Channel Register Front End

This block is the software-visible register file that sits in front of a 64-channel DMA engine. A processor reaches it through a simple 32-bit register port with per-byte write enables and a registered read path. Each per-channel bitmap is split across two 32-bit words. The upper word holds channels 63 to 32, with bit n standing for channel 32+n. The lower word holds channels 31 to 0. The bitmaps are request enable, error-interrupt enable, interrupt request and error.

Software can change one channel's bit without a read-modify-write. It writes a channel number into one byte of one of two command words. Each byte lane of those words is its own command. Some commands set or clear bitmap bits. Others fire a one-cycle strobe toward the engines, to start a channel or to clear its done state.

The engines report per-channel completion and error events. These set the interrupt-request and error bits. The first error also latches a packed error-status word that holds a valid flag, the failing channel and the cause flags. A single interrupt line summarises the pending work.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low, and `start_o`, `done_clr_o`, `req_en_o` and `route_o` are all zero.
- R2: The word registers read back what was written, under the byte enables (lane k = bits 8k+7..8k).
  - The word registers are: request enable upper/lower at 0x08/0x0C, error-interrupt enable upper/lower at 0x10/0x14, and routing upper/lower at 0x38/0x3C.
  - Control at 0x00 stores only bit 31 (clock gating), bit 3 (round-robin group) and bit 2 (round-robin channel). Its other bits read zero.
- R3: Command word 0x18 acts per byte lane:
  - lane 0 sets a request-enable bit;
  - lane 1 clears a request-enable bit;
  - lane 2 sets an error-interrupt-enable bit;
  - lane 3 clears an error-interrupt-enable bit.
  - In the written byte, bits 5:0 are the channel and bit 6 selects all 64 channels. Bit 7 is ignored.
- R4: Lane 2 of command word 0x1C raises `start_o[ch]` for exactly the one cycle after the write edge. Lane 3 does the same on `done_clr_o`. Neither command leaves any stored state.
- R5: A high `int_evt_i[ch]` or `err_evt_i[ch]` at a clock edge sets that channel's interrupt-request or error bit. An event wins over a software clear in the same cycle.
- R6: Writes to interrupt request (0x20/0x24) and error (0x28/0x2C) clear each bit written as 1 in an enabled lane. Bits written as 0 are unchanged.
- R7: Lane 0 of 0x1C clears one channel's interrupt-request bit, or all of them with bit 6. Lane 1 of 0x1C clears the error bit the same way and also clears the error-status word.
- R8: Error status at 0x04 is captured only while its valid bit is clear, so the first error is kept. Its layout is:
  - bit 31: valid;
  - bits 15 and 14: `err_cause_i[9:8]`;
  - bits 13:8: the lowest-numbered channel erroring in that cycle;
  - bits 7:0: `err_cause_i[7:0]`.
- R9: `irq_o` is high when any interrupt-request bit is set, or when any error bit is set together with its error-interrupt-enable bit.
- R10: A read returns data with `rd_valid_o` one cycle after `rd_en_i`. Command words and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write byte offset (word aligned) |
| wr_be_i | input | 4 | Write byte enables |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 8 | Read byte offset |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| int_evt_i | input | 64 | Per-channel completion events |
| err_evt_i | input | 64 | Per-channel error events |
| err_cause_i | input | 10 | Cause flags for the error status |
| start_o | output | 64 | One-cycle channel start strobes |
| done_clr_o | output | 64 | One-cycle done-clear strobes |
| req_en_o | output | 64 | Request enable bitmap |
| route_o | output | 64 | Interrupt routing select bits |
| clk_gate_en_o | output | 1 | Dynamic clock gating enable |
| rr_group_o | output | 1 | Round-robin group arbitration |
| rr_chan_o | output | 1 | Round-robin channel arbitration |
| irq_o | output | 1 | Combined interrupt |

## Verification
A wrong bitmap bit shows up in three places. It appears on the next read of its word, two cycles after the cause. If it is an interrupt or an enabled error bit, it also appears on `irq_o` in the very next cycle. If it is a request enable, `req_en_o` shows it at once.

A mis-decoded channel byte sets a neighbouring channel or misses the all-channels case, which is visible in the following read. A bad strobe path fires on the wrong line, or lasts a second cycle, which the bench checks directly. A mis-latched error status overwrites the first failing channel, which is caught by a read after a second error.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
    localparam int NCH   = 64;
    localparam int CH_W  = $clog2(NCH);
    localparam int AW    = 8;
    localparam int DW    = 32;
    localparam int BEW   = DW / 8;
    localparam int CAUSE_W = 10;

    typedef logic [AW-1:0] addr_t;

    localparam addr_t OFF_CTRL    = 8'h00;
    localparam addr_t OFF_ESTAT   = 8'h04;
    localparam addr_t OFF_ERQ_HI  = 8'h08;
    localparam addr_t OFF_ERQ_LO  = 8'h0C;
    localparam addr_t OFF_EEI_HI  = 8'h10;
    localparam addr_t OFF_EEI_LO  = 8'h14;
    localparam addr_t OFF_CMD_A   = 8'h18;
    localparam addr_t OFF_CMD_B   = 8'h1C;
    localparam addr_t OFF_IRQ_HI  = 8'h20;
    localparam addr_t OFF_IRQ_LO  = 8'h24;
    localparam addr_t OFF_ERR_HI  = 8'h28;
    localparam addr_t OFF_ERR_LO  = 8'h2C;
    localparam addr_t OFF_RT_HI   = 8'h38;
    localparam addr_t OFF_RT_LO   = 8'h3C;

    // byte-lane meaning inside the two command words
    typedef enum int {
        LANE_SET_ERQ = 0, LANE_CLR_ERQ = 1, LANE_SET_EEI = 2, LANE_CLR_EEI = 3
    } cmd_a_lane_e;
    typedef enum int {
        LANE_CLR_INT = 0, LANE_CLR_ERR = 1, LANE_START = 2, LANE_CLR_DONE = 3
    } cmd_b_lane_e;

    typedef struct packed {
        logic            valid;
        logic            grp_prio;
        logic            chan_prio;
        logic [CH_W-1:0] chan;
        logic [7:0]      cause;
    } estat_t;

    function automatic logic [DW-1:0] estat_word(estat_t s);
        return {s.valid, 15'b0, s.grp_prio, s.chan_prio, s.chan, s.cause};
    endfunction

    // bit 6 of the command byte selects every channel
    function automatic logic [NCH-1:0] chan_mask(logic [7:0] b);
        logic [NCH-1:0] m;
        if (b[6]) m = '1;
        else      m = NCH'(1) << b[CH_W-1:0];
        return m;
    endfunction

    function automatic logic [DW-1:0] be_mask(logic [BEW-1:0] be);
        logic [DW-1:0] m;
        for (int i = 0; i < BEW; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

    function automatic logic [CH_W-1:0] lowest_set(logic [NCH-1:0] v);
        logic [CH_W-1:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) if (v[i]) r = CH_W'(i);
        return r;
    endfunction
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
    import dma_regs_pkg::*;
(
    input  logic                 wr_en_i,
    input  addr_t                addr_i,
    input  logic [BEW-1:0]       be_i,
    input  logic [DW-1:0]        wdata_i,
    output logic [NCH-1:0]       erq_set_o,
    output logic [NCH-1:0]       erq_clr_o,
    output logic [NCH-1:0]       eei_set_o,
    output logic [NCH-1:0]       eei_clr_o,
    output logic [NCH-1:0]       int_clr_o,
    output logic [NCH-1:0]       err_clr_o,
    output logic [NCH-1:0]       start_o,
    output logic [NCH-1:0]       done_clr_o,
    output logic                 estat_clr_o
);
    logic hit_a, hit_b;
    logic [NCH-1:0] mask_a [BEW];
    logic [NCH-1:0] mask_b [BEW];

    assign hit_a = wr_en_i && (addr_i == OFF_CMD_A);
    assign hit_b = wr_en_i && (addr_i == OFF_CMD_B);

    for (genvar g = 0; g < BEW; g++) begin : g_lane
        assign mask_a[g] = (hit_a && be_i[g]) ? chan_mask(wdata_i[8*g +: 8]) : '0;
        assign mask_b[g] = (hit_b && be_i[g]) ? chan_mask(wdata_i[8*g +: 8]) : '0;
    end

    assign erq_set_o   = mask_a[LANE_SET_ERQ];
    assign erq_clr_o   = mask_a[LANE_CLR_ERQ];
    assign eei_set_o   = mask_a[LANE_SET_EEI];
    assign eei_clr_o   = mask_a[LANE_CLR_EEI];
    assign int_clr_o   = mask_b[LANE_CLR_INT];
    assign err_clr_o   = mask_b[LANE_CLR_ERR];
    assign start_o     = mask_b[LANE_START];
    assign done_clr_o  = mask_b[LANE_CLR_DONE];
    assign estat_clr_o = hit_b && be_i[LANE_CLR_ERR];

    // R3: a command addresses one channel or all of them, never a partial set
    always_comb begin
        if (!$isunknown(start_o) && !$isunknown(erq_set_o)) begin
            assert_single_or_all_R3: assert (($countones(start_o) <= 1 || start_o == '1) &&
                                             ($countones(erq_set_o) <= 1 || erq_set_o == '1));
        end
    end
endmodule

// File: rtl/dma_chan_bitmap.sv
module dma_chan_bitmap
    import dma_regs_pkg::*;
#(
    parameter bit W1C = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_hi_i,
    input  logic                 wr_lo_i,
    input  logic [BEW-1:0]       be_i,
    input  logic [DW-1:0]        wdata_i,
    input  logic [NCH-1:0]       set_i,
    input  logic [NCH-1:0]       clr_i,
    output logic [NCH-1:0]       q_o
);
    logic [NCH-1:0] q, nxt;
    logic [DW-1:0]  wm;

    always_comb begin
        wm  = be_mask(be_i) & wdata_i;
        nxt = q;
        if (W1C) begin
            if (wr_lo_i) nxt[DW-1:0]   = nxt[DW-1:0]   & ~wm;
            if (wr_hi_i) nxt[NCH-1:DW] = nxt[NCH-1:DW] & ~wm;
        end else begin
            if (wr_lo_i) nxt[DW-1:0]   = (nxt[DW-1:0]   & ~be_mask(be_i)) | wm;
            if (wr_hi_i) nxt[NCH-1:DW] = (nxt[NCH-1:DW] & ~be_mask(be_i)) | wm;
        end
        nxt = (nxt & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign q_o = q;

    // R5: a set request always lands, whatever else happens that cycle
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/dma_err_status.sv
module dma_err_status
    import dma_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       err_evt_i,
    input  logic [CAUSE_W-1:0]   cause_i,
    input  logic                 clr_i,
    output estat_t               q_o
);
    estat_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if ((!q.valid || clr_i) && (|err_evt_i)) begin
            q.valid     <= 1'b1;
            q.grp_prio  <= cause_i[9];
            q.chan_prio <= cause_i[8];
            q.chan      <= lowest_set(err_evt_i);
            q.cause     <= cause_i[7:0];
        end else if (clr_i) begin
            q <= '0;
        end
    end

    assign q_o = q;

    // R8: once valid, the captured word holds until software clears it
    assert_first_error_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (q.valid && !clr_i) |=> $stable(q));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en_i,
    input  logic [AW-1:0]        wr_addr_i,
    input  logic [BEW-1:0]       wr_be_i,
    input  logic [DW-1:0]        wr_data_i,
    input  logic                 rd_en_i,
    input  logic [AW-1:0]        rd_addr_i,
    output logic                 rd_valid_o,
    output logic [DW-1:0]        rd_data_o,
    input  logic [NCH-1:0]       int_evt_i,
    input  logic [NCH-1:0]       err_evt_i,
    input  logic [CAUSE_W-1:0]   err_cause_i,
    output logic [NCH-1:0]       start_o,
    output logic [NCH-1:0]       done_clr_o,
    output logic [NCH-1:0]       req_en_o,
    output logic [NCH-1:0]       route_o,
    output logic                 clk_gate_en_o,
    output logic                 rr_group_o,
    output logic                 rr_chan_o,
    output logic                 irq_o
);
    logic [NCH-1:0] erq_set, erq_clr, eei_set, eei_clr;
    logic [NCH-1:0] int_clr, err_clr, start_m, done_m;
    logic           estat_clr;
    logic [NCH-1:0] erq_q, eei_q, irq_q, err_q;
    estat_t         estat_q;
    logic [DW-1:0]  wmask;
    logic [DW-1:0]  route_hi, route_lo;
    logic           gate_q, rrg_q, rrc_q;
    logic [NCH-1:0] start_q, done_q;

    function automatic logic wr_at(addr_t off);
        return wr_en_i && (wr_addr_i == off);
    endfunction

    dma_cmd_decode u_dec (
        .wr_en_i     (wr_en_i),
        .addr_i      (wr_addr_i),
        .be_i        (wr_be_i),
        .wdata_i     (wr_data_i),
        .erq_set_o   (erq_set),
        .erq_clr_o   (erq_clr),
        .eei_set_o   (eei_set),
        .eei_clr_o   (eei_clr),
        .int_clr_o   (int_clr),
        .err_clr_o   (err_clr),
        .start_o     (start_m),
        .done_clr_o  (done_m),
        .estat_clr_o (estat_clr)
    );

    dma_chan_bitmap #(.W1C(1'b0)) u_erq (
        .clk(clk), .rst(rst),
        .wr_hi_i(wr_at(OFF_ERQ_HI)), .wr_lo_i(wr_at(OFF_ERQ_LO)),
        .be_i(wr_be_i), .wdata_i(wr_data_i),
        .set_i(erq_set), .clr_i(erq_clr), .q_o(erq_q)
    );

    dma_chan_bitmap #(.W1C(1'b0)) u_eei (
        .clk(clk), .rst(rst),
        .wr_hi_i(wr_at(OFF_EEI_HI)), .wr_lo_i(wr_at(OFF_EEI_LO)),
        .be_i(wr_be_i), .wdata_i(wr_data_i),
        .set_i(eei_set), .clr_i(eei_clr), .q_o(eei_q)
    );

    dma_chan_bitmap #(.W1C(1'b1)) u_irq (
        .clk(clk), .rst(rst),
        .wr_hi_i(wr_at(OFF_IRQ_HI)), .wr_lo_i(wr_at(OFF_IRQ_LO)),
        .be_i(wr_be_i), .wdata_i(wr_data_i),
        .set_i(int_evt_i), .clr_i(int_clr), .q_o(irq_q)
    );

    dma_chan_bitmap #(.W1C(1'b1)) u_err (
        .clk(clk), .rst(rst),
        .wr_hi_i(wr_at(OFF_ERR_HI)), .wr_lo_i(wr_at(OFF_ERR_LO)),
        .be_i(wr_be_i), .wdata_i(wr_data_i),
        .set_i(err_evt_i), .clr_i(err_clr), .q_o(err_q)
    );

    dma_err_status u_estat (
        .clk(clk), .rst(rst),
        .err_evt_i(err_evt_i), .cause_i(err_cause_i),
        .clr_i(estat_clr), .q_o(estat_q)
    );

    assign wmask = be_mask(wr_be_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            route_hi <= '0;
            route_lo <= '0;
            gate_q   <= 1'b0;
            rrg_q    <= 1'b0;
            rrc_q    <= 1'b0;
            start_q  <= '0;
            done_q   <= '0;
        end else begin
            if (wr_at(OFF_RT_HI)) route_hi <= (route_hi & ~wmask) | (wr_data_i & wmask);
            if (wr_at(OFF_RT_LO)) route_lo <= (route_lo & ~wmask) | (wr_data_i & wmask);
            if (wr_at(OFF_CTRL)) begin
                if (wr_be_i[3]) gate_q <= wr_data_i[31];
                if (wr_be_i[0]) begin
                    rrg_q <= wr_data_i[3];
                    rrc_q <= wr_data_i[2];
                end
            end
            start_q <= start_m;
            done_q  <= done_m;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_en_i;
            if (rd_en_i) begin
                case (rd_addr_i)
                    OFF_CTRL:   rd_data_o <= {gate_q, 27'b0, rrg_q, rrc_q, 2'b0};
                    OFF_ESTAT:  rd_data_o <= estat_word(estat_q);
                    OFF_ERQ_HI: rd_data_o <= erq_q[NCH-1:DW];
                    OFF_ERQ_LO: rd_data_o <= erq_q[DW-1:0];
                    OFF_EEI_HI: rd_data_o <= eei_q[NCH-1:DW];
                    OFF_EEI_LO: rd_data_o <= eei_q[DW-1:0];
                    OFF_IRQ_HI: rd_data_o <= irq_q[NCH-1:DW];
                    OFF_IRQ_LO: rd_data_o <= irq_q[DW-1:0];
                    OFF_ERR_HI: rd_data_o <= err_q[NCH-1:DW];
                    OFF_ERR_LO: rd_data_o <= err_q[DW-1:0];
                    OFF_RT_HI:  rd_data_o <= route_hi;
                    OFF_RT_LO:  rd_data_o <= route_lo;
                    default:    rd_data_o <= '0;
                endcase
            end
        end
    end

    assign start_o       = start_q;
    assign done_clr_o    = done_q;
    assign req_en_o      = erq_q;
    assign route_o       = {route_hi, route_lo};
    assign clk_gate_en_o = gate_q;
    assign rr_group_o    = rrg_q;
    assign rr_chan_o     = rrc_q;
    assign irq_o         = (|irq_q) || (|(err_q & eei_q));

    // R4: a start strobe only follows a start command written the cycle before
    assert_start_from_cmd_R4: assert property (@(posedge clk) disable iff (rst)
        (|start_o) |-> $past(wr_en_i && wr_addr_i == OFF_CMD_B && wr_be_i[LANE_START]));

    // R9: a completion event always raises the interrupt in the next cycle
    assert_int_evt_raises_irq_R9: assert property (@(posedge clk) disable iff (rst)
        (|int_evt_i) |=> irq_o);

    // R10: read data valid tracks the read strobe with one cycle of latency
    assert_read_latency_R10: assert property (@(posedge clk) disable iff (rst)
        rd_en_i |=> rd_valid_o);
endmodule

// File: tb/tb_dma_chan_regs.sv
`timescale 1ns/1ps
module tb_dma_chan_regs;
    import dma_regs_pkg::*;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [BEW-1:0] wr_be = '0;
    logic [DW-1:0]  wr_data = '0;
    logic           rd_en = 1'b0;
    logic [AW-1:0]  rd_addr = '0;
    logic           rd_valid;
    logic [DW-1:0]  rd_data;
    logic [NCH-1:0] int_evt = '0;
    logic [NCH-1:0] err_evt = '0;
    logic [CAUSE_W-1:0] err_cause = '0;
    logic [NCH-1:0] start_w, done_w, req_en, route;
    logic           gate, rrg, rrc, irq;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #10 clk = ~clk;

    dma_chan_regs dut (
        .clk(clk), .rst(rst),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_be_i(wr_be), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
        .int_evt_i(int_evt), .err_evt_i(err_evt), .err_cause_i(err_cause),
        .start_o(start_w), .done_clr_o(done_w), .req_en_o(req_en), .route_o(route),
        .clk_gate_en_o(gate), .rr_group_o(rrg), .rr_chan_o(rrc), .irq_o(irq)
    );

    task automatic check(string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops scoreboard entries as read data appears
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected read", 64'(rd_data), 64'(0));
            end else begin
                automatic logic [DW-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, 64'(rd_data), 64'(e));
            end
        end
    end

    task automatic wr(addr_t a, logic [DW-1:0] d, logic [BEW-1:0] be);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic rd(addr_t a, logic [DW-1:0] exp, string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(20ns * 100000);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 64'(irq), 64'(0));
        check("R1 start", start_w, '0);
        check("R1 req_en", req_en, '0);
        check("R1 route", route, '0);
        rd(OFF_CTRL,   32'h0, "R1 ctrl");
        rd(OFF_ESTAT,  32'h0, "R1 estat");
        rd(OFF_IRQ_HI, 32'h0, "R1 irq_hi");

        // R2 word registers with byte enables
        wr(OFF_ERQ_HI, 32'hA5A5_0001, 4'hF);
        rd(OFF_ERQ_HI, 32'hA5A5_0001, "R2 erq_hi full");
        wr(OFF_ERQ_HI, 32'hFFFF_FFFF, 4'b0010);
        rd(OFF_ERQ_HI, 32'hA5A5_FF01, "R2 erq_hi lane1");
        wr(OFF_CTRL, 32'hFFFF_FFFF, 4'b0001);
        rd(OFF_CTRL, 32'h0000_000C, "R2 ctrl lane0");
        wr(OFF_CTRL, 32'hFFFF_FFFF, 4'b1000);
        rd(OFF_CTRL, 32'h8000_000C, "R2 ctrl lane3");
        check("R2 ctrl pins", {61'b0, gate, rrg, rrc}, 64'h7);
        wr(OFF_RT_HI, 32'hDEAD_BEEF, 4'hF);
        wr(OFF_RT_LO, 32'h0000_1234, 4'hF);
        check("R2 route", route, 64'hDEAD_BEEF_0000_1234);

        // R3 set/clear commands
        wr(OFF_CMD_A, 32'h0000_0085, 4'b0001);      // bit 7 ignored -> channel 5
        rd(OFF_ERQ_LO, 32'h0000_0020, "R3 set erq ch5");
        wr(OFF_CMD_A, 32'd33, 4'b0001);
        rd(OFF_ERQ_HI, 32'hA5A5_FF03, "R3 set erq ch33");
        wr(OFF_CMD_A, 32'h0000_4000, 4'b0010);      // clear all
        rd(OFF_ERQ_HI, 32'h0, "R3 clear all erq hi");
        check("R3 req_en all cleared", req_en, '0);
        wr(OFF_CMD_A, 32'd63 << 16, 4'b0100);
        rd(OFF_EEI_HI, 32'h8000_0000, "R3 set eei ch63");
        wr(OFF_CMD_A, 32'd63 << 24, 4'b1000);
        rd(OFF_EEI_HI, 32'h0, "R3 clear eei ch63");

        // R4 strobes
        wr(OFF_CMD_B, 32'd10 << 16, 4'b0100);
        check("R4 start ch10", start_w, 64'(1) << 10);
        @(negedge clk);
        check("R4 start one cycle", start_w, '0);
        wr(OFF_CMD_B, 32'h40 << 24, 4'b1000);
        check("R4 done_clr all", done_w, '1);
        @(negedge clk);
        check("R4 done_clr one cycle", done_w, '0);
        rd(OFF_CMD_B, 32'h0, "R10 cmd reads zero");

        // R5 / R6 / R9 interrupt bits
        @(negedge clk);
        int_evt = (64'(1) << 3) | (64'(1) << 35);
        @(negedge clk);
        int_evt = '0;
        check("R9 irq on int", 64'(irq), 64'(1));
        rd(OFF_IRQ_LO, 32'h8, "R5 int lo");
        rd(OFF_IRQ_HI, 32'h8, "R5 int hi");
        wr(OFF_IRQ_LO, 32'h0, 4'hF);
        rd(OFF_IRQ_LO, 32'h8, "R6 zero write keeps");
        wr(OFF_IRQ_LO, 32'h8, 4'hF);
        rd(OFF_IRQ_LO, 32'h0, "R6 w1c clears");
        @(negedge clk);
        int_evt = 64'(1) << 7;
        wr_en = 1'b1; wr_addr = OFF_IRQ_LO; wr_data = 32'h80; wr_be = 4'hF;
        @(negedge clk);
        int_evt = '0; wr_en = 1'b0; wr_be = '0;
        rd(OFF_IRQ_LO, 32'h80, "R5 event beats clear");
        wr(OFF_CMD_B, 32'd7, 4'b0001);
        rd(OFF_IRQ_LO, 32'h0, "R7 clear int ch7");
        wr(OFF_IRQ_HI, 32'hFFFF_FFFF, 4'hF);
        check("R9 irq low", 64'(irq), 64'(0));

        // R8 error status
        @(negedge clk);
        err_evt = (64'(1) << 5) | (64'(1) << 40);
        err_cause = 10'b10_0000_0101;
        @(negedge clk);
        err_evt = '0; err_cause = '0;
        rd(OFF_ESTAT, 32'h8000_8505, "R8 first capture");
        rd(OFF_ERR_LO, 32'h20, "R5 err lo");
        rd(OFF_ERR_HI, 32'h100, "R5 err hi");
        check("R9 err without enable", 64'(irq), 64'(0));
        @(negedge clk);
        err_evt = 64'(1) << 3; err_cause = 10'b01_1000_0000;
        @(negedge clk);
        err_evt = '0; err_cause = '0;
        rd(OFF_ESTAT, 32'h8000_8505, "R8 first error kept");
        rd(OFF_ERR_LO, 32'h28, "R5 second err");

        // R9 enabled error
        wr(OFF_CMD_A, 32'd40 << 16, 4'b0100);
        check("R9 irq enabled err", 64'(irq), 64'(1));
        wr(OFF_CMD_B, 32'd40 << 8, 4'b0010);
        check("R7 irq after err clear", 64'(irq), 64'(0));
        rd(OFF_ERR_HI, 32'h0, "R7 err ch40 cleared");
        rd(OFF_ESTAT, 32'h0, "R7 estat cleared");
        wr(OFF_CMD_B, 32'h40 << 8, 4'b0010);
        rd(OFF_ERR_LO, 32'h0, "R7 clear all errors");

        // R10 unmapped
        rd(8'h30, 32'h0, "R10 unmapped");
        rd(OFF_CMD_A, 32'h0, "R10 cmd A zero");

        repeat (2) @(negedge clk);
        check("R10 scoreboard drained", 64'(exp_q.size()), 64'(0));
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule